// File: doc/BRIEF.md
# Stream-Fired Accumulator Operator

This block is a finite state machine operator whose only contact with the rest of the chip is three streams. It has an operand input stream, a command input stream and one result output stream, and each uses a valid/ready handshake. The operator keeps an accumulator and a state register and no other storage. It has no memory port and no side path into its registers.

Each state names the set of input streams that must hold a token before the state may fire. A firing takes one clock cycle. It consumes exactly the required tokens, updates the registers and may place one token on the output. While a state is waiting, a token on an input it does not need stays where it is, because that input's ready is held low.

The states are `ST_ACC`, which needs an operand; `ST_CTRL`, which needs a command; and `ST_DONE`, which needs nothing and never fires. The transitions are:
- `ST_ACC -> ST_CTRL` on an operand firing.
- `ST_CTRL -> ST_ACC` on a continue or flush command.
- `ST_CTRL -> ST_DONE` on a finish command.

Because operands and commands arrive at data-dependent rates, the number of results per operand is set by the command stream and not by a fixed schedule.

Top module: `sfo_stream_op`

## Requirements
- R1: A synchronous active-high reset puts the FSM in `ST_ACC`, clears the accumulator and drives `done` and `y_valid` low.
- R2: In `ST_ACC`, `a_ready` is 1 and `b_ready` is 0. A cycle with `a_valid` high fires: it adds twice the unsigned operand to the accumulator and moves to `ST_CTRL`.
- R3: In `ST_CTRL`, `a_ready` is 0, and `b_ready` is 1 unless the presented command emits while `y_ready` is 0.
- R4: Command code 0 (continue) emits nothing, keeps the accumulator and returns to `ST_ACC`.
- R5: Command code 1 (flush) presents the accumulator on `y_data` with `y_valid` high. When it is accepted, the accumulator clears and the FSM returns to `ST_ACC`.
- R6: Command code 2 (finish) presents the accumulator on the output. When it is accepted, the FSM moves to `ST_DONE`. From then on `done` stays 1, both readies stay 0 and `y_valid` stays 0 until reset.
- R7: A command that would emit while `y_ready` is 0 stalls in full: `b_ready` is 0, no token is consumed and no register changes.
- R8: Command code 3 is reserved and behaves exactly like continue.
- R9: An operand token offered while in `ST_CTRL` is neither consumed nor added; it has no effect on any later result.
- R10: The accumulator wraps modulo 2^ACC_W.
- R11: `y_valid` is high only in `ST_CTRL`, when `b_valid` is high with command 1 or 2. It does not depend on `y_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_valid | input | 1 | Operand token present |
| a_ready | output | 1 | Operand token taken this cycle if valid |
| a_data | input | DATA_W | Unsigned operand |
| b_valid | input | 1 | Command token present |
| b_ready | output | 1 | Command token taken this cycle if valid |
| b_cmd | input | 2 | Command: 0 continue, 1 flush, 2 finish, 3 reserved |
| y_valid | output | 1 | Result token present |
| y_ready | input | 1 | Downstream takes the result |
| y_data | output | ACC_W | Accumulator value being emitted |
| done | output | 1 | Operator has finished |

## Verification
The assertions assume that the inputs carry no unknown values and that `b_cmd` is meaningful whenever `b_valid` is high. They also assume that `y_ready` is free to change in any cycle, independent of `y_valid`.

The stimulus drives every input to a defined value on the falling edge. It draws `y_ready` and both valids independently from a seeded generator, so stalls, ignored operand tokens and reserved commands all appear in random order. After a finish command, the stimulus runs a few more cycles and then applies reset.

// File: rtl/sfo_pkg.sv
package sfo_pkg;

    typedef enum logic [1:0] {
        ST_ACC  = 2'd0,
        ST_CTRL = 2'd1,
        ST_DONE = 2'd2
    } sfo_state_t;

    typedef enum logic [1:0] {
        CMD_CONT   = 2'd0,
        CMD_FLUSH  = 2'd1,
        CMD_FINISH = 2'd2,
        CMD_RSVD   = 2'd3
    } sfo_cmd_t;

    localparam int unsigned SFO_NUM_IN = 2;
    localparam int unsigned SFO_IN_A   = 0;
    localparam int unsigned SFO_IN_B   = 1;

    // Required-input set per state: bit SFO_IN_A = operand, bit SFO_IN_B = command
    function automatic logic [SFO_NUM_IN-1:0] sfo_req_set(input sfo_state_t st);
        logic [SFO_NUM_IN-1:0] m;
        m = '0;
        unique case (st)
            ST_ACC:  m[SFO_IN_A] = 1'b1;
            ST_CTRL: m[SFO_IN_B] = 1'b1;
            ST_DONE: m = '0;
            default: m = '0;
        endcase
        return m;
    endfunction

    function automatic logic sfo_cmd_emits(input logic [1:0] c);
        return (c == CMD_FLUSH) || (c == CMD_FINISH);
    endfunction

endpackage

// File: rtl/sfo_fire_gate.sv
module sfo_fire_gate #(
    parameter int unsigned N_IN = 2
) (
    input  logic [N_IN-1:0] req,
    input  logic [N_IN-1:0] in_valid,
    input  logic            wants_emit,
    input  logic            out_ready,
    output logic [N_IN-1:0] in_ready,
    output logic            fire
);
    logic [N_IN-1:0] sat;
    logic            emit_ok;

    assign sat     = in_valid | ~req;
    assign emit_ok = !wants_emit || out_ready;
    assign fire    = (|req) && (&sat) && emit_ok;

    for (genvar k = 0; k < N_IN; k++) begin : g_rdy
        logic [N_IN-1:0] others;
        assign others      = sat | (N_IN'(1) << k);
        assign in_ready[k] = req[k] && (&others) && emit_ok;
    end

endmodule

// File: rtl/sfo_accum.sv
module sfo_accum #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ACC_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              add_en,
    input  logic              clr,
    input  logic [DATA_W-1:0] add_val,
    output logic [ACC_W-1:0]  acc
);
    localparam int unsigned SHIFTED_W = DATA_W + 1;

    logic [ACC_W-1:0] addend;

    assign addend = ACC_W'({add_val, 1'b0});

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (clr) begin
            acc <= '0;
        end else if (add_en) begin
            acc <= acc + addend;
        end
    end

    // R2 R10
    acc_add_chk: assert property (@(posedge clk) disable iff (rst)
        add_en && !clr |=> (acc - $past(acc)) == ACC_W'($past({add_val, 1'b0})));

    // R5
    acc_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> acc == '0);

    // R4
    acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !add_en && !clr |=> $stable(acc));

    initial begin
        assert (SHIFTED_W <= ACC_W) else $error("ACC_W too narrow for 2*operand");
    end

endmodule

// File: rtl/sfo_stream_op.sv
module sfo_stream_op #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ACC_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              a_valid,
    output logic              a_ready,
    input  logic [DATA_W-1:0] a_data,
    input  logic              b_valid,
    output logic              b_ready,
    input  logic [1:0]        b_cmd,
    output logic              y_valid,
    input  logic              y_ready,
    output logic [ACC_W-1:0]  y_data,
    output logic              done
);
    import sfo_pkg::*;

    sfo_state_t              state_q, state_d;
    logic [SFO_NUM_IN-1:0]   req;
    logic [SFO_NUM_IN-1:0]   in_valid;
    logic [SFO_NUM_IN-1:0]   in_ready;
    logic                    fire;
    logic                    cmd_emit;
    logic                    wants_emit;
    logic                    add_en;
    logic                    clr;
    logic [ACC_W-1:0]        acc;

    assign req        = sfo_req_set(state_q);
    assign cmd_emit   = sfo_cmd_emits(b_cmd);
    assign wants_emit = (state_q == ST_CTRL) && cmd_emit;

    assign in_valid[SFO_IN_A] = a_valid;
    assign in_valid[SFO_IN_B] = b_valid;

    sfo_fire_gate #(.N_IN(SFO_NUM_IN)) u_gate (
        .req        (req),
        .in_valid   (in_valid),
        .wants_emit (wants_emit),
        .out_ready  (y_ready),
        .in_ready   (in_ready),
        .fire       (fire)
    );

    sfo_accum #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .add_en  (add_en),
        .clr     (clr),
        .add_val (a_data),
        .acc     (acc)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_ACC;
        else     state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACC: begin
                if (fire) state_d = ST_CTRL;
            end
            ST_CTRL: begin
                if (fire) begin
                    unique case (sfo_cmd_t'(b_cmd))
                        CMD_FINISH: state_d = ST_DONE;
                        CMD_CONT, CMD_FLUSH, CMD_RSVD: state_d = ST_ACC;
                        default: state_d = ST_ACC;
                    endcase
                end
            end
            ST_DONE: state_d = ST_DONE;
            default: state_d = ST_ACC;
        endcase
    end

    // Outputs
    always_comb begin
        a_ready = in_ready[SFO_IN_A];
        b_ready = in_ready[SFO_IN_B];
        y_valid = 1'b0;
        add_en  = 1'b0;
        clr     = 1'b0;
        unique case (state_q)
            ST_ACC: begin
                add_en = fire;
            end
            ST_CTRL: begin
                y_valid = b_valid && cmd_emit;
                clr     = fire && (b_cmd == CMD_FLUSH);
            end
            ST_DONE: begin
                y_valid = 1'b0;
            end
            default: begin
                y_valid = 1'b0;
            end
        endcase
    end

    assign y_data = acc;
    assign done   = (state_q == ST_DONE);

    // R2 R3
    ready_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({a_ready, b_ready}));

    // R7
    stall_chk: assert property (@(posedge clk) disable iff (rst)
        y_valid && !y_ready |-> !b_ready);

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        y_valid && !y_ready |=> $stable(acc) && $stable(state_q));

    // R6
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    // R6
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !a_ready && !b_ready && !y_valid);

    // R5
    flush_chk: assert property (@(posedge clk) disable iff (rst)
        b_valid && b_ready && b_cmd == 2'd1 |=> acc == '0 && state_q == ST_ACC);

    // R11
    yvalid_state_chk: assert property (@(posedge clk) disable iff (rst)
        y_valid |-> state_q == ST_CTRL && b_valid);

    // R9
    a_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_CTRL && a_valid |-> !a_ready);

endmodule

// File: tb/sfo_stream_op_tb.sv
module sfo_stream_op_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          a_valid = 1'b0, b_valid = 1'b0, y_ready = 1'b0;
    logic [DW-1:0] a_data = '0;
    logic [1:0]    b_cmd = '0;
    logic          a_ready, b_ready, y_valid, done;
    logic [AW-1:0] y_data;

    int checks = 0;
    int failures = 0;
    int m_state = 0;
    logic [AW-1:0] m_acc = '0;
    int prev_cmd = -1;
    string ydata_tag = "";
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sfo_stream_op #(.DATA_W(DW), .ACC_W(AW)) u_dut (
        .clk(clk), .rst(rst),
        .a_valid(a_valid), .a_ready(a_ready), .a_data(a_data),
        .b_valid(b_valid), .b_ready(b_ready), .b_cmd(b_cmd),
        .y_valid(y_valid), .y_ready(y_ready), .y_data(y_data),
        .done(done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit emits(input logic [1:0] c);
        return (c == 2'd1) || (c == 2'd2);
    endfunction

    function automatic logic [AW-1:0] acc_add(input logic [AW-1:0] a, input logic [DW-1:0] d);
        logic [AW-1:0] two;
        two = AW'(d) * AW'(2);
        return a + two;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; a_valid = 0; b_valid = 0; y_ready = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_state = 0; m_acc = '0; prev_cmd = -1;
        #1;
        chk("R1 a_ready", a_ready, 1);
        chk("R1 b_ready", b_ready, 0);
        chk("R1 y_valid", y_valid, 0);
        chk("R1 done", done, 0);
    endtask

    task automatic cycle(input logic av, input logic [DW-1:0] ad,
                         input logic bv, input logic [1:0] bc, input logic yr);
        bit   e_ay, e_by, e_yv, ecmd;
        string atag, btag;
        @(negedge clk);
        a_valid = av; a_data = ad; b_valid = bv; b_cmd = bc; y_ready = yr;
        #1;
        ecmd = emits(bc);
        e_ay = (m_state == 0);
        e_by = (m_state == 1) && (!ecmd || yr);
        e_yv = (m_state == 1) && bv && ecmd;
        if (m_state == 2) atag = "R6";
        else if (m_state == 1) atag = av ? "R9" : "R3";
        else if (prev_cmd == 3) atag = "R8";
        else if (prev_cmd == 0) atag = "R4";
        else atag = "R2";
        btag = (m_state == 1 && ecmd && !yr) ? "R7" : (m_state == 2 ? "R6" : "R3");
        chk({atag, " a_ready"}, a_ready, e_ay);
        chk({btag, " b_ready"}, b_ready, e_by);
        chk("R11 y_valid", y_valid, e_yv);
        chk("R6 done", done, m_state == 2);
        if (e_yv) begin
            chk(ydata_tag != "" ? ydata_tag : (bc == 2'd1 ? "R5 y_data" : "R6 y_data"),
                y_data, m_acc);
        end
        prev_cmd = -1;
        if (m_state == 0 && av) begin
            m_acc = acc_add(m_acc, ad);
            m_state = 1;
        end else if (m_state == 1 && bv && e_by) begin
            prev_cmd = bc;
            if (bc == 2'd1) begin m_acc = '0; m_state = 0; end
            else if (bc == 2'd2) m_state = 2;
            else m_state = 0;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        int unsigned r;
        void'($urandom(32'd4242));
        do_reset();
        // R2 R9 R5: operand, ignored operand in control state, flush
        cycle(1, 8'd5, 0, 0, 0);
        cycle(1, 8'd100, 0, 0, 1);
        cycle(0, 0, 1, 2'd1, 1);
        // R7 stall then accept
        cycle(1, 8'd3, 0, 0, 0);
        cycle(0, 0, 1, 2'd1, 0);
        cycle(1, 8'd9, 1, 2'd1, 0);
        cycle(0, 0, 1, 2'd1, 0);
        cycle(0, 0, 1, 2'd1, 1);
        // R4 R8 continue and reserved
        cycle(1, 8'd1, 0, 0, 0);
        cycle(0, 0, 1, 2'd0, 0);
        cycle(1, 8'd2, 0, 0, 0);
        cycle(0, 0, 1, 2'd3, 0);
        cycle(1, 8'd4, 0, 0, 0);
        ydata_tag = "R4 R8 y_data";
        cycle(0, 0, 1, 2'd1, 1);
        // R10 wrap: 130 * 510 mod 65536 = 764
        for (int i = 0; i < 130; i++) begin
            cycle(1, 8'd255, 0, 0, 0);
            cycle(0, 0, 1, 2'd0, 1);
        end
        cycle(1, 8'd0, 0, 0, 0);
        chk("R10 model", m_acc, 16'd764);
        ydata_tag = "R10 y_data";
        cycle(0, 0, 1, 2'd1, 1);
        ydata_tag = "";
        // R6 finish
        cycle(1, 8'd7, 0, 0, 0);
        cycle(0, 0, 1, 2'd2, 1);
        for (int i = 0; i < 4; i++) cycle(1, 8'd1, 1, 2'd1, 1);
        do_reset();
        // random phase
        for (int n = 0; n < 3000; n++) begin
            logic [1:0] c;
            r = $urandom % 16;
            c = (r < 8) ? 2'd0 : (r < 12) ? 2'd1 : (r < 15) ? 2'd3 : 2'd2;
            cycle(1'($urandom % 2), 8'($urandom), 1'($urandom % 2), c, 1'($urandom % 3 != 0));
            if (m_state == 2 && ($urandom % 4 == 0)) do_reset();
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule